// File: doc/BRIEF.md
# Write-Protected Watchdog Timer

This block watches for software that has stopped making progress. A counter advances on prescaled ticks from one of two oscillator sources. If software does not clear it before it runs past its top value, the block raises a non-maskable interrupt request. Everything runs in one system clock domain. Each oscillator arrives as a single-cycle tick-enable input, and each has its own divide-by-16 prescaler. The prescaler is a free-running counter that advances only on its own source's ticks.

Software reaches the block through a small write port with three one-bit registers, each chosen by a 2-bit address. The first selects the count source. The second is a one-shot unlock that must be set before the source select will accept a write. The third is a strobe that clears the counter.

Two inputs report the processor's power state. While `halt_i` is high, counting continues, and an overflow also requests release from halt. While `sleep_i` is high, both prescalers and the counter hold their values. Counting resumes from those values when sleep ends. With a 32.768 kHz first source and the default 12-bit counter, the service period is 4096 × 16 / 32768 = 2 s.

Top module: `nmi_watchdog`

## Requirements
- R1: Each prescaler counts only the ticks of its own source and emits one count pulse on every 2^PRE_W-th tick (16 by default). The counter (CNT_W bits, 12 by default) advances by one on each pulse from the selected source, and the new value appears on `count_o` after that clock edge.
- R2: After reset, `sel_o` is 1, `wen_o` is 0, `count_o` is 0 and both pulse outputs are low. `sel_o` = 1 counts from source A (`tick_a_i`), and `sel_o` = 0 counts from source B (`tick_b_i`). Ticks from the unselected source never move the counter.
- R3: A write to address 0 (source select) while `wen_o` is 0 leaves `sel_o` unchanged.
- R4: A write with data 1 to address 1 (unlock) sets `wen_o`. The next write to address 0 loads `sel_o` from the write data and clears `wen_o` in the same edge. A write with data 0 to address 1 has no effect.
- R5: A write with data 1 to address 2 (service strobe) makes `count_o` 0 after that edge. A write with data 0 to address 2 has no effect.
- R6: When a count pulse arrives with the counter at its maximum value, the counter wraps to 0 and keeps counting. In the same edge `nmi_o` goes high for exactly one cycle.
- R7: If a service strobe and an overflowing count pulse fall in the same cycle, the counter becomes 0 and `nmi_o` stays low.
- R8: Counting continues while `halt_i` is high. An overflow while `halt_i` is high also pulses `halt_rel_o` for one cycle, together with `nmi_o`. `halt_rel_o` is never high without `nmi_o`.
- R9: While `sleep_i` is high, neither prescaler nor the counter changes, except for a service strobe. After sleep ends, counting continues from the held values.
- R10: Changing the source select resets neither prescaler. Each prescaler keeps its count phase across select changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_a_i | input | 1 | Single-cycle tick from source A (select value 1) |
| tick_b_i | input | 1 | Single-cycle tick from source B (select value 0) |
| sleep_i | input | 1 | Sleep state: freeze prescalers and counter |
| halt_i | input | 1 | Halt state: an overflow also requests halt release |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 select, 1 unlock, 2 service |
| wdata_i | input | 1 | Register write data |
| sel_o | output | 1 | Current source select |
| wen_o | output | 1 | Unlock pending for one select write |
| count_o | output | CNT_W | Current watchdog count |
| nmi_o | output | 1 | One-cycle non-maskable interrupt request |
| halt_rel_o | output | 1 | One-cycle halt release request |

## Verification
The hardest case to reach from the ports is a service strobe that lands in the same cycle as an overflowing count pulse. That needs the counter at its maximum and the selected prescaler at its last phase, with a tick present. The bench builds the design with a 6-bit counter and a divide-by-4 prescaler. It keeps a cycle-accurate arithmetic model of both prescaler phases and the count, so it can run the counter up to the exact cycle and fire the strobe there. The same model lets it sweep full periods under several tick patterns, interleave sleep and halt, and switch sources partway through a prescaler phase.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_SEL    = 2'd0,
    REG_UNLOCK = 2'd1,
    REG_SERVE  = 2'd2,
    REG_SPARE  = 2'd3
  } wdt_reg_e;

  localparam int NUM_SRC = 2;
  localparam int SRC_A   = 1;
  localparam int SRC_B   = 0;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic run_i,
  output logic pulse_o
);

  localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

  logic [PRE_W-1:0] phase_q;
  logic             adv;

  assign adv     = tick_i & run_i;
  assign pulse_o = adv & (phase_q == PRE_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (adv) begin
      phase_q <= phase_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wdata_i,
  output logic              sel_o,
  output logic              wen_o,
  output logic              serve_o
);

  logic sel_q;
  logic wen_q;
  logic hit_sel;
  logic hit_unlock;

  assign hit_sel    = wr_i & (addr_i == REG_SEL);
  assign hit_unlock = wr_i & (addr_i == REG_UNLOCK) & wdata_i;
  assign serve_o    = wr_i & (addr_i == REG_SERVE) & wdata_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b1;
      wen_q <= 1'b0;
    end else begin
      if (hit_sel && wen_q) begin
        sel_q <= wdata_i;
        wen_q <= 1'b0;
      end else if (hit_unlock) begin
        wen_q <= 1'b1;
      end
    end
  end

  assign sel_o = sel_q;
  assign wen_o = wen_q;

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             serve_i,
  input  logic             halt_i,
  output logic [CNT_W-1:0] count_o,
  output logic             nmi_o,
  output logic             halt_rel_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             nmi_q;
  logic             rel_q;
  logic             wrap;

  assign wrap = step_i & ~serve_i & (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      nmi_q <= 1'b0;
      rel_q <= 1'b0;
    end else begin
      nmi_q <= wrap;
      rel_q <= wrap & halt_i;
      if (serve_i) begin
        cnt_q <= '0;
      end else if (step_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign count_o    = cnt_q;
  assign nmi_o      = nmi_q;
  assign halt_rel_o = rel_q;

endmodule

// File: rtl/nmi_watchdog.sv
module nmi_watchdog
  import wdt_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_a_i,
  input  logic             tick_b_i,
  input  logic             sleep_i,
  input  logic             halt_i,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic             wdata_i,
  output logic             sel_o,
  output logic             wen_o,
  output logic [CNT_W-1:0] count_o,
  output logic             nmi_o,
  output logic             halt_rel_o
);

  logic [NUM_SRC-1:0] src_tick;
  logic [NUM_SRC-1:0] src_pulse;
  logic               serve;
  logic               step;
  logic               run;

  assign src_tick[SRC_A] = tick_a_i;
  assign src_tick[SRC_B] = tick_b_i;
  assign run             = ~sleep_i;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_pre
      wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (src_tick[g]),
        .run_i   (run),
        .pulse_o (src_pulse[g])
      );
    end
  endgenerate

  wdt_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .sel_o   (sel_o),
    .wen_o   (wen_o),
    .serve_o (serve)
  );

  assign step = sel_o ? src_pulse[SRC_A] : src_pulse[SRC_B];

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .step_i     (step),
    .serve_i    (serve),
    .halt_i     (halt_i),
    .count_o    (count_o),
    .nmi_o      (nmi_o),
    .halt_rel_o (halt_rel_o)
  );

endmodule

// File: rtl/nmi_watchdog_chk.sv
module nmi_watchdog_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             sleep_i,
  input logic             wr_i,
  input logic [1:0]       addr_i,
  input logic             wdata_i,
  input logic             sel_o,
  input logic             wen_o,
  input logic [CNT_W-1:0] count_o,
  input logic             nmi_o,
  input logic             halt_rel_o
);

  logic serve_w;
  logic sel_w;
  assign serve_w = wr_i && addr_i == 2'd2 && wdata_i;
  assign sel_w   = wr_i && addr_i == 2'd0;

  a_r2_reset_state: assert property (@(posedge clk)
    rst |=> (sel_o && !wen_o && count_o == '0 && !nmi_o && !halt_rel_o));

  a_r3_locked_select: assert property (@(posedge clk) disable iff (rst)
    (sel_w && !wen_o) |=> (sel_o == $past(sel_o)));

  a_r4_one_shot: assert property (@(posedge clk) disable iff (rst)
    (sel_w && wen_o) |=> (!wen_o && sel_o == $past(wdata_i)));

  a_r5_serve_clears: assert property (@(posedge clk) disable iff (rst)
    serve_w |=> (count_o == '0));

  a_r7_serve_blocks_nmi: assert property (@(posedge clk) disable iff (rst)
    serve_w |=> !nmi_o);

  a_r6_nmi_single: assert property (@(posedge clk) disable iff (rst)
    nmi_o |=> !nmi_o);

  a_r6_nmi_wraps: assert property (@(posedge clk) disable iff (rst)
    nmi_o |-> (count_o == '0));

  a_r8_release_with_nmi: assert property (@(posedge clk) disable iff (rst)
    halt_rel_o |-> nmi_o);

  a_r9_sleep_hold: assert property (@(posedge clk) disable iff (rst)
    (sleep_i && !serve_w) |=> (count_o == $past(count_o) && !nmi_o));

endmodule

bind nmi_watchdog nmi_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sleep_i    (sleep_i),
  .wr_i       (wr_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .sel_o      (sel_o),
  .wen_o      (wen_o),
  .count_o    (count_o),
  .nmi_o      (nmi_o),
  .halt_rel_o (halt_rel_o)
);

// File: tb/nmi_watchdog_tb.sv
module nmi_watchdog_tb;

  localparam int CW   = 6;
  localparam int PW   = 2;
  localparam int PMAX = (1 << PW) - 1;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ta = 1'b0, tb = 1'b0, slp = 1'b0, hlt = 1'b0;
  logic          wr = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic          wd = 1'b0;
  logic          sel, wen, nmi, hrel;
  logic [CW-1:0] cnt;

  int checks = 0;
  int fails  = 0;
  int pa = 0, pb = 0, mc = 0;
  int msel = 1, mwen = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nmi_watchdog #(.CNT_W(CW), .PRE_W(PW)) u_dut (
    .clk(clk), .rst(rst), .tick_a_i(ta), .tick_b_i(tb), .sleep_i(slp),
    .halt_i(hlt), .wr_i(wr), .addr_i(addr), .wdata_i(wd),
    .sel_o(sel), .wen_o(wen), .count_o(cnt), .nmi_o(nmi), .halt_rel_o(hrel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model the edge, compare at next negedge
  task automatic cyc(input bit a, input bit b, input bit s, input bit h,
                     input bit w, input int ad, input bit d, input string tag);
    bit adone, bdone, step, serve, ovf;
    ta = a; tb = b; slp = s; hlt = h; wr = w; addr = 2'(ad); wd = d;
    adone = a && !s && pa == PMAX;
    bdone = b && !s && pb == PMAX;
    if (a && !s) pa = (pa + 1) & PMAX;
    if (b && !s) pb = (pb + 1) & PMAX;
    step  = (msel == 1) ? adone : bdone;
    serve = w && ad == 2 && d;
    ovf   = step && !serve && mc == CMAX;
    if (serve) mc = 0;
    else if (step) mc = (mc + 1) & CMAX;
    if (w && ad == 0 && mwen == 1) begin msel = d; mwen = 0; end
    else if (w && ad == 1 && d) mwen = 1;
    @(negedge clk);
    chk({tag, " R1 count"}, int'(cnt), mc);
    chk({tag, " R6 nmi"}, int'(nmi), int'(ovf));
    chk({tag, " R8 halt release"}, int'(hrel), int'(ovf && h));
    chk({tag, " R3 select"}, int'(sel), msel);
    chk({tag, " R4 unlock"}, int'(wen), mwen);
  endtask

  task automatic idle_ticks(input int n, input bit a, input bit b, input string tag);
    for (int i = 0; i < n; i++) cyc(a, b, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2: reset state
    chk("R2 reset sel", int'(sel), 1);
    chk("R2 reset wen", int'(wen), 0);
    chk("R2 reset count", int'(cnt), 0);
    chk("R2 reset nmi", int'(nmi), 0);

    // R1/R6: full period on source A with a tick every cycle, through the wrap
    idle_ticks(2 * 4 * (CMAX + 1) + 10, 1, 0, "R1/R6 A continuous");
    // R2: source B ignored while A is selected
    idle_ticks(37, 0, 1, "R2 B ignored");
    // R1: sparse A ticks, every third cycle
    for (int i = 0; i < 300; i++) cyc(i % 3 == 0, 1, 0, 0, 0, 0, 0, "R1 A sparse");

    // R3: locked select write
    cyc(0, 0, 0, 0, 1, 0, 0, "R3 locked write");
    // R4: unlock with data 0 has no effect
    cyc(0, 0, 0, 0, 1, 1, 0, "R4 unlock zero");
    cyc(0, 0, 0, 0, 1, 0, 0, "R3 still locked");
    // R4: unlock, one write takes effect, second is locked out
    cyc(0, 0, 0, 0, 1, 1, 1, "R4 unlock");
    cyc(0, 0, 0, 0, 1, 0, 0, "R4 write sel=0");
    cyc(0, 0, 0, 0, 1, 0, 1, "R4 relocked");

    // R10: B phase kept from earlier B ticks; now B counts, A ignored
    for (int i = 0; i < 600; i++) cyc(i % 2 == 0, 1, 0, 0, 0, 0, 0, "R10 B selected");

    // R5: service strobe, and strobe with data 0
    idle_ticks(5, 0, 1, "R5 pre");
    cyc(0, 1, 0, 0, 1, 2, 0, "R5 serve zero");
    cyc(0, 1, 0, 0, 1, 2, 1, "R5 serve");

    // R9: sleep freezes, resume continues
    idle_ticks(9, 0, 1, "R9 pre");
    for (int i = 0; i < 40; i++) cyc(1, 1, 1, 0, 0, 0, 0, "R9 sleeping");
    idle_ticks(30, 0, 1, "R9 resumed");
    cyc(0, 1, 1, 0, 1, 2, 1, "R9 serve in sleep");

    // R8: halt, counting continues and overflow releases halt
    for (int i = 0; i < 4 * (CMAX + 1) + 20; i++) cyc(0, 1, 0, 1, 0, 0, 0, "R8 halt");

    // R10: switch back to A mid-phase
    cyc(0, 0, 0, 0, 1, 1, 1, "R10 unlock");
    cyc(0, 0, 0, 0, 1, 0, 1, "R10 write sel=1");
    idle_ticks(50, 1, 1, "R10 A again");

    // R7: serve strobe in the exact overflow cycle
    cyc(0, 0, 0, 0, 1, 2, 1, "R7 align serve");
    while (!(mc == CMAX && pa == PMAX)) cyc(1, 0, 0, 0, 0, 0, 0, "R7 run up");
    cyc(1, 0, 0, 1, 1, 2, 1, "R7 collide");
    idle_ticks(20, 1, 0, "R7 after");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule